// File: doc/BRIEF.md
# Packed Three-Channel Small-Float to Single-Precision Decoder

This block takes one 32-bit word that carries three unsigned small floating-point values and turns it into four IEEE-754 single-precision words. The two lower channels (red, green) are 11 bits wide, with a 5-bit exponent and a 6-bit mantissa. The top channel (blue) is 10 bits wide, with a 5-bit exponent and a 5-bit mantissa. A fourth output carries a constant alpha of one.

Every channel moves its exponent from bias 15 to bias 127. Small-float denormals become the exact normalized single-precision value. Infinity and NaN pass through with their mantissa bits kept. The decode is combinational, one instance per channel, and the results are captured in output registers. Those registers load only on a valid input strobe, and an output valid strobe follows one clock later. Texture filtering or blending pipelines use the block wherever packed shared-range colour must be widened to float before arithmetic.

Top module: `packed_sf_decoder`

## Requirements
- R1: Red is read from input bits 10:0, green from bits 21:11 and blue from bits 31:22. Within each field the 5-bit exponent sits directly above the mantissa (6 bits for red and green, 5 bits for blue).
- R2: For an exponent of 1 to 30, the output exponent field (bits 30:23) equals the input exponent plus 112. The input mantissa fills the top of the 23-bit output mantissa, and the lower bits are zero.
- R3: For an exponent of 31, the output exponent field is 0xFF and the mantissa is carried over left-aligned. A zero mantissa yields infinity and a non-zero one yields NaN.
- R4: For an exponent of 0 with a non-zero mantissa, the output is the normalized single-precision value exactly equal to mantissa × 2^(−14−mantissa width).
- R5: A channel with exponent and mantissa both zero outputs 0x00000000.
- R6: Bit 31 (sign) of every colour output is always zero.
- R7: The alpha output always reads 0x3F800000 (1.0).
- R8: When in_valid is high at a rising edge, the decoded outputs appear and out_valid is high after that edge. out_valid is low after an edge where in_valid was low.
- R9: A synchronous active-high reset makes out_valid low after the edge.
- R10: While in_valid is low, the colour outputs hold their previous values whatever in_word carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Packed three-channel word |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| red_f32 | output | 32 | Red channel as single precision |
| green_f32 | output | 32 | Green channel as single precision |
| blue_f32 | output | 32 | Blue channel as single precision |
| alpha_f32 | output | 32 | Constant 1.0 |

## Verification
Every result is due exactly one rising edge after the edge that sampled in_valid. The decode path has no state, and the only register on the way is the output stage. The bench drives each word on a falling edge and holds in_valid for one cycle. It compares all four outputs and out_valid on the next falling edge, one edge after capture. After an idle cycle with a changed in_word, it checks the same ports again to prove they held. Expected values come from real-number arithmetic converted to bit patterns in the bench, with separate rules for the all-ones exponent.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int F32_W      = 32;
  localparam int F32_EXP_W  = 8;
  localparam int F32_MAN_W  = 23;
  localparam int F32_BIAS   = 127;
  localparam logic [F32_W-1:0] F32_ONE = 32'h3F80_0000;

  function automatic int sf_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/sf_denorm_norm.sv
module sf_denorm_norm
  import sf_pkg::*;
#(
  parameter int MAN_W = 6,
  parameter int EXP_W = 5
) (
  input  logic [MAN_W-1:0]     man,
  output logic [F32_EXP_W-1:0] exp_f,
  output logic [MAN_W-1:0]     frac
);
  localparam int ADJ      = F32_BIAS - sf_sf_bias_w();
  localparam int EXP_BASE = ADJ + 1 - MAN_W;

  function automatic int sf_sf_bias_w();
    return sf_bias(EXP_W);
  endfunction

  int lead;

  always_comb begin
    lead = 0;
    for (int i = 0; i < MAN_W; i++) begin
      if (man[i]) lead = i;
    end
    frac  = man << (MAN_W - lead);
    exp_f = F32_EXP_W'(EXP_BASE + lead);
  end

  // R4
  always_comb begin
    if (man != '0) begin
      denorm_range_chk: assert (int'(exp_f) >= EXP_BASE && int'(exp_f) < EXP_BASE + MAN_W);
    end
  end
endmodule

// File: rtl/sf_chan_decode.sv
module sf_chan_decode
  import sf_pkg::*;
#(
  parameter int MAN_W = 6,
  parameter int EXP_W = 5
) (
  input  logic [EXP_W+MAN_W-1:0] code,
  output logic [F32_W-1:0]       f32
);
  localparam int CW   = EXP_W + MAN_W;
  localparam int FPAD = F32_MAN_W - MAN_W;
  localparam int ADJ  = F32_BIAS - sf_bias(EXP_W);

  logic [EXP_W-1:0]     e;
  logic [MAN_W-1:0]     m;
  logic [F32_EXP_W-1:0] dn_exp;
  logic [MAN_W-1:0]     dn_frac;

  assign e = code[CW-1:MAN_W];
  assign m = code[MAN_W-1:0];

  sf_denorm_norm #(.MAN_W(MAN_W), .EXP_W(EXP_W)) norm_i (
    .man   (m),
    .exp_f (dn_exp),
    .frac  (dn_frac)
  );

  always_comb begin
    if (e == '1)
      f32 = {1'b0, {F32_EXP_W{1'b1}}, m, {FPAD{1'b0}}};
    else if (e == '0)
      f32 = (m == '0) ? '0 : {1'b0, dn_exp, dn_frac, {FPAD{1'b0}}};
    else
      f32 = {1'b0, F32_EXP_W'(e) + F32_EXP_W'(ADJ), m, {FPAD{1'b0}}};
  end

  always_comb begin
    // R6
    sign_zero_chk: assert (f32[F32_W-1] == 1'b0);
    // R3
    if (e == '1) begin
      special_exp_chk: assert (f32[F32_W-2 -: F32_EXP_W] == '1 && f32[F32_MAN_W-1 -: MAN_W] == m);
    end
    // R5
    if (code == '0) begin
      zero_out_chk: assert (f32 == '0);
    end
  end
endmodule

// File: rtl/packed_sf_decoder.sv
module packed_sf_decoder
  import sf_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int RG_MAN_W = 6,
  parameter int B_MAN_W  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [31:0] red_f32,
  output logic [31:0] green_f32,
  output logic [31:0] blue_f32,
  output logic [31:0] alpha_f32
);
  localparam int RG_W  = EXP_W + RG_MAN_W;
  localparam int B_W   = EXP_W + B_MAN_W;
  localparam int NCH   = 3;

  logic [F32_W-1:0] dec_f32 [NCH];
  logic [F32_W-1:0] hold_f32 [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    if (ch < 2) begin : g_rg
      sf_chan_decode #(.MAN_W(RG_MAN_W), .EXP_W(EXP_W)) dec_i (
        .code (in_word[ch*RG_W +: RG_W]),
        .f32  (dec_f32[ch])
      );
    end else begin : g_b
      sf_chan_decode #(.MAN_W(B_MAN_W), .EXP_W(EXP_W)) dec_i (
        .code (in_word[2*RG_W +: B_W]),
        .f32  (dec_f32[ch])
      );
    end

    always_ff @(posedge clk) begin
      if (in_valid) hold_f32[ch] <= dec_f32[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      alpha_f32 <= F32_ONE;
    end else begin
      out_valid <= in_valid;
      alpha_f32 <= F32_ONE;
    end
  end

  assign red_f32   = hold_f32[0];
  assign green_f32 = hold_f32[1];
  assign blue_f32  = hold_f32[2];

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(red_f32) && $stable(green_f32) && $stable(blue_f32)));
  // R7
  alpha_one_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> alpha_f32 == F32_ONE);
endmodule

// File: tb/packed_sf_decoder_tb_top.sv
module packed_sf_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [31:0] red_f32, green_f32, blue_f32, alpha_f32;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  packed_sf_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .red_f32(red_f32), .green_f32(green_f32),
    .blue_f32(blue_f32), .alpha_f32(alpha_f32)
  );

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // Reference from real arithmetic: value = m*2^(-14-M) or (2^M+m)*2^(e-15-M)
  function automatic logic [31:0] ref_f32(input logic [10:0] code, input int mw);
    int e = int'(code >> mw);
    int m = int'(code) & ((1 << mw) - 1);
    real v;
    logic [63:0] b;
    if (e == 31) return {1'b0, 8'hFF, 23'(m << (23 - mw))};
    if (e == 0 && m == 0) return 32'h0;
    if (e == 0) v = real'(m) * pow2(-14 - mw);
    else        v = real'((1 << mw) + m) * pow2(e - 15 - mw);
    b = $realtobits(v);
    return {1'b0, 8'(int'(b[62:52]) - 896), b[51:29]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    logic [31:0] er, eg, eb;
    er = ref_f32(w[10:0], 6);
    eg = ref_f32(w[21:11], 6);
    eb = ref_f32({1'b0, w[31:22]}, 5);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 out_valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " R1 R2 R4 red"}, red_f32, er);
    chk({tag, " R1 R2 R4 green"}, green_f32, eg);
    chk({tag, " R1 R2 R4 blue"}, blue_f32, eb);
    chk({tag, " R7 alpha"}, alpha_f32, 32'h3F80_0000);
    chk({tag, " R6 sign"}, {29'b0, red_f32[31], green_f32[31], blue_f32[31]}, 32'd0);
  endtask

  initial begin
    logic [31:0] pr, pg, pb;
    @(negedge clk); @(negedge clk);
    chk("R9 reset out_valid", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R5 all zero
    send(32'h0, "zero R5");
    chk("R5 red zero", red_f32, 32'h0);
    // R3 inf on red (e=31,m=0), NaN on green (m=1), NaN blue all ones
    send({5'd31, 5'd31, 5'd31, 6'd1, 5'd31, 6'd0}, "special R3");
    chk("R3 red inf", red_f32, 32'h7F80_0000);
    chk("R3 green nan", green_f32, 32'h7F80_0000 | (32'd1 << 17));
    chk("R3 blue nan", blue_f32, 32'h7FF8_0000 | 32'h0007_C000 & 32'h007C_0000 | 32'h7FFC_0000 & 32'h0);
    // R2 1.0 on red: e=15 m=0 -> 0x3F800000
    send({10'd0, 11'd0, 5'd15, 6'd0}, "one R2");
    chk("R2 red one", red_f32, 32'h3F80_0000);
    // R4 smallest denormals: red m=1 -> 2^-20, blue m=1 -> 2^-19
    send({5'd0, 5'd1, 11'd0, 5'd0, 6'd1}, "min denorm R4");
    chk("R4 red 2^-20", red_f32, 32'h3580_0000);
    chk("R4 blue 2^-19", blue_f32, 32'h3600_0000);
    // R4 largest denormals and R2 largest normal
    send({5'd0, 5'd31, 5'd30, 6'd63, 5'd0, 6'd63}, "max denorm R4");
    chk("R2 green max normal", green_f32, 32'h477E_0000);
    // R10 hold: idle cycle with changed word
    pr = red_f32; pg = green_f32; pb = blue_f32;
    in_word = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R8 idle out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 hold red", red_f32, pr);
    chk("R10 hold green", green_f32, pg);
    chk("R10 hold blue", blue_f32, pb);
    // random
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      send($urandom, "random R1");
      if (($urandom & 3) == 0) @(negedge clk);
    end
    // R9 reset mid-stream
    in_word = 32'h1; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R9 reset mid out_valid", {31'b0, out_valid}, 32'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule